// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block collects one instruction of an 8-bit processor from a byte-wide memory read port. An instruction is one to four bytes long. It may start with a single prefix byte. One opcode byte always follows. The prefix and the opcode together decide whether zero, one or two operand bytes follow. The block holds a program counter that serves as the read address and moves forward by one for every byte it takes. When the final byte has arrived, the block shows the prefix, the opcode, the operands and the byte count, and raises a one-cycle completion strobe.

A controller starts a fetch with `start_i`. Memory answers the request by showing a byte on `mem_rdata_i` together with `mem_ready_i`. A byte is taken on each clock edge where the request and ready are both high. Holding `start_i` high fetches instructions back to back. Execution and flag handling belong to other blocks.

Top module: `ifs_fetch_seq`

## Requirements
- R1: While reset is high and right after it, `done_o`, `mem_req_o`, `has_prefix_o` and `length_o` are zero, and `mem_addr_o` equals the RESET_PC parameter (default 0).
- R2: If the first byte of an instruction is 0xCB, 0xDD, 0xED or 0xFD, it is taken as a prefix: `has_prefix_o` is 1 and `prefix_o` holds that byte. Any other first byte is the opcode, and `has_prefix_o` is 0.
- R3: The byte that follows a prefix is always the opcode, even when it is itself one of the four prefix values.
- R4: Without a prefix, 0x3E takes one operand (length 2) and 0x21 takes two operands (length 3). Every other opcode, 0xAF, 0x46 and 0x5B among them, has length 1.
- R5: After prefix 0xDD or 0xFD, opcode 0x46 takes one displacement operand (length 3) and opcode 0x21 takes two operands (length 4). Any other opcode after these prefixes has length 2.
- R6: After prefix 0xED, opcode 0x5B takes a two-byte absolute address (length 4), and any other opcode has length 2. After prefix 0xCB, every opcode has length 2.
- R7: `operands_o[7:0]` holds the first operand byte and `operands_o[15:8]` holds the second. Operand bytes that were not fetched read as zero.
- R8: The program counter moves forward by exactly one for each byte taken, and it carries on from one instruction to the next. At `done_o`, `mem_addr_o` is the address just past the instruction.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, the address, the collected fields and the sequencing stay as they are, and the request stays high.
- R10: `done_o` is high for exactly one cycle, starting on the cycle after the last byte is taken, and `mem_req_o` is low in that cycle. After it, the block goes idle. If `start_i` is high during the done cycle, it instead starts the next fetch on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a fetch (sampled when idle or in the done cycle) |
| mem_rdata_i | input | 8 | Byte read from memory at `mem_addr_o` |
| mem_ready_i | input | 1 | `mem_rdata_i` is valid in this cycle |
| mem_req_o | output | 1 | A byte read is pending |
| mem_addr_o | output | ADDR_W | Program counter used as the read address |
| has_prefix_o | output | 1 | The instruction carried a prefix byte |
| prefix_o | output | 8 | Prefix byte, zero when absent |
| opcode_o | output | 8 | Opcode byte |
| operands_o | output | 16 | Operand bytes, first operand in the low byte, zero-filled |
| length_o | output | 3 | Bytes in the instruction, 1 to 4 |
| done_o | output | 1 | One-cycle strobe: the fields are complete |

## Verification
The assertions check properties that hold on every cycle:
- the counter steps by one on each taken byte and holds otherwise;
- a request stays high through wait cycles;
- the done strobe never lasts two cycles and never overlaps a request;
- a prefixed instruction never reports a length below two;
- an instruction with no operands shows zero operands;
- no more than one field is captured per cycle.

Which operand count each prefix and opcode pair receives can only be shown by the bench. It sweeps every unprefixed opcode and a set of opcodes behind each prefix, with and without wait cycles. It also runs the back-to-back start case and an extended stall.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    localparam int BYTE_W   = 8;
    localparam int MAX_OPND = 2;
    localparam int MAX_LEN  = MAX_OPND + 2;
    localparam int LEN_W    = $clog2(MAX_LEN + 1);
    localparam int CNT_W    = $clog2(MAX_OPND + 1);
    localparam int IDX_W    = (MAX_OPND > 1) ? $clog2(MAX_OPND) : 1;
    localparam int OPND_W   = BYTE_W * MAX_OPND;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t PFX_BITOP = 8'hCB;
    localparam byte_t PFX_IXREG = 8'hDD;
    localparam byte_t PFX_EXTND = 8'hED;
    localparam byte_t PFX_IYREG = 8'hFD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_OPC,
        ST_OPND,
        ST_DONE
    } fetch_state_e;

    typedef struct packed {
        logic               has_pfx;
        byte_t              pfx;
        byte_t              opc;
        logic [OPND_W-1:0]  opnd;
        logic [LEN_W-1:0]   len;
    } instr_t;

    function automatic logic is_prefix(byte_t b);
        return (b == PFX_BITOP) || (b == PFX_IXREG) ||
               (b == PFX_EXTND) || (b == PFX_IYREG);
    endfunction

    function automatic logic [CNT_W-1:0] operand_count(logic has_pfx, byte_t pfx, byte_t opc);
        logic [CNT_W-1:0] n;
        n = '0;
        if (!has_pfx) begin
            if (opc == 8'h3E)      n = CNT_W'(1);
            else if (opc == 8'h21) n = CNT_W'(2);
        end else if (pfx == PFX_IXREG || pfx == PFX_IYREG) begin
            if (opc == 8'h46)      n = CNT_W'(1);
            else if (opc == 8'h21) n = CNT_W'(2);
        end else if (pfx == PFX_EXTND) begin
            if (opc == 8'h5B)      n = CNT_W'(2);
        end
        return n;
    endfunction

endpackage

// File: rtl/ifs_len_decode.sv
module ifs_len_decode
    import ifs_pkg::*;
(
    input  logic             has_pfx_i,
    input  byte_t            pfx_i,
    input  byte_t            opc_i,
    output logic [CNT_W-1:0] nops_o
);

    always_comb begin
        nops_o = operand_count(has_pfx_i, pfx_i, opc_i);
    end

endmodule

// File: rtl/ifs_pc_counter.sv
module ifs_pc_counter #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [ADDR_W-1:0] pc_o
);

    always_ff @(posedge clk) begin
        if (rst)         pc_o <= RESET_PC;
        else if (step_i) pc_o <= pc_o + 1'b1;
    end

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (pc_o == $past(pc_o) + 1'b1));                 // R8

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(pc_o));                               // R9

endmodule

// File: rtl/ifs_field_reg.sv
module ifs_field_reg
    import ifs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             sel_pfx_i,
    input  logic             sel_opc_i,
    input  logic             sel_opnd_i,
    input  logic [IDX_W-1:0] idx_i,
    input  byte_t            byte_i,
    output instr_t           fields_o
);

    logic              has_pfx_q;
    byte_t             pfx_q;
    byte_t             opc_q;
    logic [LEN_W-1:0]  len_q;
    logic [OPND_W-1:0] opnd_flat;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            has_pfx_q <= 1'b0;
            pfx_q     <= '0;
            opc_q     <= '0;
            len_q     <= '0;
        end else begin
            if (sel_pfx_i) begin
                has_pfx_q <= 1'b1;
                pfx_q     <= byte_i;
            end
            if (sel_opc_i) opc_q <= byte_i;
            if (sel_pfx_i || sel_opc_i || sel_opnd_i) len_q <= len_q + 1'b1;
        end
    end

    for (genvar g = 0; g < MAX_OPND; g++) begin : g_lane
        byte_t lane_q;
        always_ff @(posedge clk) begin
            if (rst || clr_i)
                lane_q <= '0;
            else if (sel_opnd_i && idx_i == IDX_W'(g))
                lane_q <= byte_i;
        end
        assign opnd_flat[g*BYTE_W +: BYTE_W] = lane_q;
    end

    always_comb begin
        fields_o.has_pfx = has_pfx_q;
        fields_o.pfx     = pfx_q;
        fields_o.opc     = opc_q;
        fields_o.opnd    = opnd_flat;
        fields_o.len     = len_q;
    end

    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $countones({sel_pfx_i, sel_opc_i, sel_opnd_i}) <= 1);     // R3

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        len_q <= LEN_W'(MAX_LEN));                                // R6

endmodule

// File: rtl/ifs_fetch_seq.sv
module ifs_fetch_seq
    import ifs_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [7:0]        mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              has_prefix_o,
    output logic [7:0]        prefix_o,
    output logic [7:0]        opcode_o,
    output logic [15:0]       operands_o,
    output logic [2:0]        length_o,
    output logic              done_o
);

    fetch_state_e     state_q, state_d;
    logic [CNT_W-1:0] remain_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] nops;
    logic             take, clr, sel_pfx, sel_opc, sel_opnd;
    instr_t           fields;

    assign mem_req_o = (state_q == ST_LEAD) || (state_q == ST_OPC) || (state_q == ST_OPND);
    assign take      = mem_req_o && mem_ready_i;
    assign done_o    = (state_q == ST_DONE);

    ifs_len_decode u_dec (
        .has_pfx_i (state_q == ST_OPC),
        .pfx_i     (fields.pfx),
        .opc_i     (mem_rdata_i),
        .nops_o    (nops)
    );

    ifs_pc_counter #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .step_i (take),
        .pc_o   (mem_addr_o)
    );

    ifs_field_reg u_fld (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr),
        .sel_pfx_i  (sel_pfx),
        .sel_opc_i  (sel_opc),
        .sel_opnd_i (sel_opnd),
        .idx_i      (idx_q),
        .byte_i     (mem_rdata_i),
        .fields_o   (fields)
    );

    always_comb begin
        state_d  = state_q;
        clr      = 1'b0;
        sel_pfx  = 1'b0;
        sel_opc  = 1'b0;
        sel_opnd = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                clr     = 1'b1;
                state_d = ST_LEAD;
            end
            ST_LEAD: if (take) begin
                if (is_prefix(mem_rdata_i)) begin
                    sel_pfx = 1'b1;
                    state_d = ST_OPC;
                end else begin
                    sel_opc = 1'b1;
                    state_d = (nops == '0) ? ST_DONE : ST_OPND;
                end
            end
            ST_OPC: if (take) begin
                sel_opc = 1'b1;
                state_d = (nops == '0) ? ST_DONE : ST_OPND;
            end
            ST_OPND: if (take) begin
                sel_opnd = 1'b1;
                if (remain_q == CNT_W'(1)) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (start_i) begin
                    clr     = 1'b1;
                    state_d = ST_LEAD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            idx_q    <= '0;
        end else begin
            state_q <= state_d;
            if (sel_opc) begin
                remain_q <= nops;
                idx_q    <= '0;
            end else if (sel_opnd) begin
                remain_q <= remain_q - 1'b1;
                idx_q    <= idx_q + 1'b1;
            end
        end
    end

    assign has_prefix_o = fields.has_pfx;
    assign prefix_o     = fields.pfx;
    assign opcode_o     = fields.opc;
    assign operands_o   = fields.opnd;
    assign length_o     = fields.len;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                      // R10

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_o);                                   // R10

    AST_REQ_WAIT: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ready_i) |=> mem_req_o);               // R9

    AST_PFX_LEN: assert property (@(posedge clk) disable iff (rst)
        (done_o && has_prefix_o) |-> (length_o >= 3'd2));         // R2

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (done_o && length_o == 3'(has_prefix_o) + 3'd1) |-> (operands_o == '0)); // R7

endmodule

// File: tb/sim_ifs_fetch_seq.sv
`timescale 1ns/1ps
module sim_ifs_fetch_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  mem_rdata;
    logic        mem_ready;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        has_prefix;
    logic [7:0]  prefix, opcode;
    logic [15:0] operands;
    logic [2:0]  length;
    logic        done;

    logic [7:0]  mem [256];
    logic        force_stall = 1'b0;
    logic        stall_mode  = 1'b0;
    int          stall_cnt   = 0;
    logic [15:0] exp_pc      = 16'h0000;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    always @(negedge clk) stall_cnt <= stall_cnt + 1;

    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_ready = !force_stall && (!stall_mode || (stall_cnt % 3 != 0));

    ifs_fetch_seq u0 (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .mem_rdata_i  (mem_rdata),
        .mem_ready_i  (mem_ready),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .has_prefix_o (has_prefix),
        .prefix_o     (prefix),
        .opcode_o     (opcode),
        .operands_o   (operands),
        .length_o     (length),
        .done_o       (done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic pfx_byte(logic [7:0] b);
        return b == 8'hCB || b == 8'hDD || b == 8'hED || b == 8'hFD;
    endfunction

    function automatic int exp_nops(logic hp, logic [7:0] p, logic [7:0] o);
        if (!hp) return (o == 8'h3E) ? 1 : (o == 8'h21) ? 2 : 0;      // R4
        if (p == 8'hDD || p == 8'hFD)
            return (o == 8'h46) ? 1 : (o == 8'h21) ? 2 : 0;           // R5
        if (p == 8'hED) return (o == 8'h5B) ? 2 : 0;                  // R6
        return 0;
    endfunction

    task automatic wait_done(output logic ok);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!ok) chk("R10 done timeout", 0, 1);
    endtask

    task automatic check_fields(input logic hp, input logic [7:0] p, o, d0, d1);
        int n;
        int len;
        logic [15:0] eops;
        string ltag;
        n    = exp_nops(hp, p, o);
        len  = (hp ? 1 : 0) + 1 + n;
        eops = (n == 0) ? 16'h0 : (n == 1) ? {8'h00, d0} : {d1, d0};
        ltag = !hp ? "R4 length" : (p == 8'hDD || p == 8'hFD) ? "R5 length" : "R6 length";
        chk("R2 has_prefix", 32'(has_prefix), 32'(hp));
        chk("R2 prefix", 32'(prefix), hp ? 32'(p) : 0);
        chk("R3 opcode", 32'(opcode), 32'(o));
        chk(ltag, 32'(length), 32'(len));
        chk("R7 operands", 32'(operands), 32'(eops));
        exp_pc = exp_pc + 16'(len);
        chk("R8 pc", 32'(mem_addr), 32'(exp_pc));
    endtask

    task automatic load(input logic hp, input logic [7:0] p, o, d0, d1);
        logic [7:0] a;
        a = exp_pc[7:0];
        if (hp) begin
            mem[a] = p;
            a = a + 8'd1;
        end
        mem[a] = o;
        mem[a + 8'd1] = d0;
        mem[a + 8'd2] = d1;
    endtask

    task automatic run_instr(input logic hp, input logic [7:0] p, o, d0, d1);
        logic ok;
        load(hp, p, o, d0, d1);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done(ok);
        if (ok) begin
            check_fields(hp, p, o, d0, d1);
            @(negedge clk);
            chk("R10 done single cycle", 32'(done), 0);
            chk("R10 idle no request", 32'(mem_req), 0);
        end
    endtask

    initial begin
        logic ok;
        logic [15:0] held;
        logic [7:0] plist [4];
        logic [7:0] olist [10];
        plist = '{8'hCB, 8'hDD, 8'hED, 8'hFD};
        olist = '{8'h00, 8'h21, 8'h46, 8'h5B, 8'hAF, 8'h3E, 8'hCB, 8'hDD, 8'hED, 8'hFD};
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        chk("R1 pc in reset", 32'(mem_addr), 0);
        rst = 1'b0;
        chk("R1 done", 32'(done), 0);
        chk("R1 request", 32'(mem_req), 0);
        chk("R1 has_prefix", 32'(has_prefix), 0);
        chk("R1 length", 32'(length), 0);
        chk("R1 pc", 32'(mem_addr), 0);

        // R4: every first byte that is not a prefix, alternating wait patterns
        for (int o = 0; o < 256; o++) begin
            if (!pfx_byte(8'(o))) begin
                stall_mode = o[0];
                run_instr(1'b0, 8'h00, 8'(o), 8'h5A ^ 8'(o), 8'hC3);
            end
        end

        // R5 R6 R3: each prefix against a set of opcodes, including prefix values
        for (int pi = 0; pi < 4; pi++) begin
            for (int oi = 0; oi < 10; oi++) begin
                stall_mode = oi[0] ^ pi[0];
                run_instr(1'b1, plist[pi], olist[oi], 8'h80 + 8'(oi), 8'h40 + 8'(pi));
            end
        end
        stall_mode = 1'b0;

        // R9: long stall during a four-byte instruction
        load(1'b1, 8'hED, 8'h5B, 8'h34, 8'h12);
        force_stall = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        held = mem_addr;
        chk("R9 request held", 32'(mem_req), 1);
        repeat (4) @(negedge clk);
        chk("R9 pc frozen", 32'(mem_addr), 32'(held));
        chk("R9 pc frozen value", 32'(mem_addr), 32'(exp_pc));
        chk("R9 request still held", 32'(mem_req), 1);
        chk("R9 no done while stalled", 32'(done), 0);
        chk("R9 length frozen", 32'(length), 0);
        force_stall = 1'b0;
        wait_done(ok);
        if (ok) check_fields(1'b1, 8'hED, 8'h5B, 8'h34, 8'h12);

        // R10: start held high gives back-to-back fetches
        @(negedge clk);
        mem[exp_pc[7:0]]         = 8'h3E;
        mem[exp_pc[7:0] + 8'd1] = 8'h11;
        mem[exp_pc[7:0] + 8'd2] = 8'hAF;
        start = 1'b1;
        @(negedge clk);
        wait_done(ok);
        if (ok) begin
            check_fields(1'b0, 8'h00, 8'h3E, 8'h11, 8'h00);
            @(negedge clk);
            chk("R10 done single cycle b2b", 32'(done), 0);
            chk("R10 next fetch started", 32'(mem_req), 1);
            wait_done(ok);
            if (ok) begin
                check_fields(1'b0, 8'h00, 8'hAF, 8'h00, 8'h00);
                start = 1'b0;
                @(negedge clk);
                chk("R10 idle after release", 32'(mem_req), 0);
                chk("R10 done dropped", 32'(done), 0);
            end
        end
        start = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule